// File: doc/BRIEF.md
# Multi-target SPI register-access master

This block is a bus-mapped SPI master that reads and writes single byte-wide registers in as many as four identical converter chips that share one serial clock and one data-in line. A bus write to the command register starts one 24-bit frame. The frame goes to every chip whose select bit is set in that command, so one write can program any subset of the chips at once. During a read frame, each selected chip returns a byte on its own data-out line. The block captures these bytes in parallel and packs them into one 32-bit receive word.

A configuration register sets the serial clock rate and drives four active-low reset lines, one per chip. Software reads bit 31 of the command register, or the `busy_o` pin, to learn when a frame has finished. A command written while a frame is still running is dropped.

Top module: `spi_mt_master`

## Requirements
- R1: Config bits [1:0] select the serial clock. Code k gives a half period of 2^k bus cycles, so code 0 runs at half the bus clock and each higher code halves the rate. The code is latched when a frame starts, so a config write during a frame affects only later frames.
- R2: Config bits 4, 5, 6 and 7 drive `chip_rst_no[0]` to `[3]` (chips A to D) directly, and they read back at the same positions. After reset the config is all zero, so every chip is held in reset and the divider code is 0.
- R3: An accepted command shifts its bits [23:0] out on `mosi_o`, MSB first, in SPI mode 0. Data changes only on a falling edge and holds steady while `sclk_o` is high. Bits [20:16] always go out as zero, whatever was written. `mosi_o` is low when idle.
- R4: Command bits 24+i select chip i. Each selected chip has `cs_no[i]` low for the whole frame. The select goes low one half period before the first rising edge and returns high one half period after the 24th falling edge. `sclk_o` idles low, and all selects are high when idle.
- R5: Command bit 23 = 1 marks a read. On the last 8 rising edges of a read frame, each chip's `miso_i[i]` is sampled MSB first. When the frame ends, that byte goes into receive bits [8i+7:8i], but only for selected chips. Unselected lanes keep their old value, and data on earlier edges is ignored.
- R6: A write frame (bit 23 = 0) leaves the whole receive register unchanged.
- R7: `busy_o` and command read-back bit 31 are 1 from the edge that accepts a command until the frame ends. A command write while busy is ignored, and this includes a write on the very cycle the frame completes.
- R8: The command register reads back bits [27:0] of the last accepted command with bits [20:16] cleared. Bits [30:28] read as zero, and address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Word select: 0 config, 1 command, 2 receive, 3 unused |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| busy_o | output | 1 | Frame in progress |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to all chips |
| cs_no | output | 4 | Active-low chip selects, bit i = chip i |
| miso_i | input | 4 | Serial data from each chip |
| chip_rst_no | output | 4 | Active-low chip resets |

## Verification
Two pairs of events can land in the same cycle. The first pair is the end of a frame, where the receive commit happens and busy drops, and a new command write. The bench places a command write exactly on the completing edge and expects it to be dropped, then issues the next write one cycle later and expects that one to start. The second pair is a config write during a frame. The bench changes the divider code mid-frame and expects the serial clock timing to stay at the latched rate until the next frame starts. A cycle-accurate model in the bench judges both cases on every clock.

// File: rtl/spi_mt_pkg.sv
package spi_mt_pkg;
  typedef enum logic [1:0] {
    REG_CFG = 2'd0,
    REG_CMD = 2'd1,
    REG_RX  = 2'd2,
    REG_NUL = 2'd3
  } reg_sel_e;

  localparam int CFG_DIV_LSB   = 0;
  localparam int CFG_RST_LSB   = 4;
  localparam int CMD_PAD_LSB   = 16;
  localparam int CMD_PAD_W     = 5;
  localparam int CMD_RNW_BIT   = 23;
  localparam int CMD_CS_LSB    = 24;
  localparam int STAT_BUSY_BIT = 31;
endpackage

// File: rtl/spi_mt_tick.sv
module spi_mt_tick #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CW = 1 << DIV_W;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half_m1;

  assign half_m1 = (CW'(1) << div_i) - CW'(1);
  assign tick_o  = run_i && (cnt_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i || !run_i || tick_o) cnt_q <= '0;
    else                             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/spi_mt_engine.sv
module spi_mt_engine #(
  parameter int FRAME_W = 24,
  parameter int N_CHIP  = 4,
  parameter int RX_BITS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [N_CHIP-1:0]  mask_i,
  input  logic               rd_i,
  input  logic               tick_i,
  output logic               busy_o,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic [N_CHIP-1:0]  cs_no,
  output logic [N_CHIP-1:0]  sel_o,
  output logic               rd_o,
  output logic               smp_o,
  output logic               done_o
);
  localparam int CNT_W = $clog2(2 * FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(2 * FRAME_W);
  localparam logic [CNT_W-1:0] SMP_FROM = CNT_W'(2 * (FRAME_W - RX_BITS));

  logic               busy_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_q;
  logic [N_CHIP-1:0]  sel_q;
  logic               rd_q;
  logic               rise;

  // half-edge count: odd = sclk high
  assign rise   = busy_q && tick_i && !cnt_q[0] && (cnt_q != LAST);
  assign smp_o  = rise && (cnt_q >= SMP_FROM);
  assign done_o = busy_q && tick_i && (cnt_q == LAST);
  assign busy_o = busy_q;
  assign sclk_o = busy_q && cnt_q[0];
  assign mosi_o = busy_q && sh_q[FRAME_W-1];
  assign cs_no  = busy_q ? ~sel_q : '1;
  assign sel_o  = sel_q;
  assign rd_o   = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      sel_q  <= '0;
      rd_q   <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        sh_q   <= frame_i;
        sel_q  <= mask_i;
        rd_q   <= rd_i;
      end
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q[0]) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
      end
    end
  end

  // R3
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  // R4
  sclk_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> (busy_o && (cs_no != '1 || sel_q == '0)));
  // R4
  idle_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no == '1 && !sclk_o && !mosi_o));
endmodule

// File: rtl/spi_mt_rx_lane.sv
module spi_mt_rx_lane #(
  parameter int RX_BITS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               smp_i,
  input  logic               miso_i,
  input  logic               commit_i,
  output logic [RX_BITS-1:0] lane_o
);
  logic [RX_BITS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      lane_o <= '0;
    end else begin
      if (smp_i)    sh_q   <= {sh_q[RX_BITS-2:0], miso_i};
      if (commit_i) lane_o <= sh_q;
    end
  end
endmodule

// File: rtl/spi_mt_master.sv
module spi_mt_master
  import spi_mt_pkg::*;
#(
  parameter int N_CHIP  = 4,
  parameter int DIV_W   = 2,
  parameter int RX_BITS = 8,
  parameter int FRAME_W = 24,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [N_CHIP-1:0] cs_no,
  input  logic [N_CHIP-1:0] miso_i,
  output logic [N_CHIP-1:0] chip_rst_no
);
  localparam int CMD_W  = CMD_CS_LSB + N_CHIP;
  localparam int RX_ALL = N_CHIP * RX_BITS;

  reg_sel_e           addr;
  logic               wr_cfg, wr_cmd, accept;
  logic [DIV_W-1:0]   div_q, div_run_q;
  logic [N_CHIP-1:0]  rst_q;
  logic [CMD_W-1:0]   cmd_q, cmd_in;
  logic               tick, smp, done, eng_rd;
  logic [N_CHIP-1:0]  eng_sel;
  logic [RX_ALL-1:0]  rx_all;

  assign addr   = reg_sel_e'(bus_addr_i);
  assign wr_cfg = bus_we_i && (addr == REG_CFG);
  assign wr_cmd = bus_we_i && (addr == REG_CMD);
  assign accept = wr_cmd && !busy_o;

  always_comb begin
    cmd_in = bus_wdata_i[CMD_W-1:0];
    cmd_in[CMD_PAD_LSB +: CMD_PAD_W] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      rst_q     <= '0;
      cmd_q     <= '0;
      div_run_q <= '0;
    end else begin
      if (wr_cfg) begin
        div_q <= bus_wdata_i[CFG_DIV_LSB +: DIV_W];
        rst_q <= bus_wdata_i[CFG_RST_LSB +: N_CHIP];
      end
      if (accept) begin
        cmd_q     <= cmd_in;
        div_run_q <= div_q;
      end
    end
  end

  spi_mt_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .clr_i  (accept),
    .div_i  (div_run_q),
    .tick_o (tick)
  );

  spi_mt_engine #(.FRAME_W(FRAME_W), .N_CHIP(N_CHIP), .RX_BITS(RX_BITS)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .frame_i (cmd_in[FRAME_W-1:0]),
    .mask_i  (cmd_in[CMD_CS_LSB +: N_CHIP]),
    .rd_i    (cmd_in[CMD_RNW_BIT]),
    .tick_i  (tick),
    .busy_o  (busy_o),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .cs_no   (cs_no),
    .sel_o   (eng_sel),
    .rd_o    (eng_rd),
    .smp_o   (smp),
    .done_o  (done)
  );

  for (genvar g = 0; g < N_CHIP; g++) begin : g_lane
    spi_mt_rx_lane #(.RX_BITS(RX_BITS)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .smp_i    (smp),
      .miso_i   (miso_i[g]),
      .commit_i (done && eng_rd && eng_sel[g]),
      .lane_o   (rx_all[g*RX_BITS +: RX_BITS])
    );

    // R5
    unsel_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!eng_sel[g] || !eng_rd) |=> $stable(rx_all[g*RX_BITS +: RX_BITS]));
  end

  assign chip_rst_no = rst_q;

  always_comb begin
    bus_rdata_o = '0;
    unique case (addr)
      REG_CFG: begin
        bus_rdata_o[CFG_DIV_LSB +: DIV_W]  = div_q;
        bus_rdata_o[CFG_RST_LSB +: N_CHIP] = rst_q;
      end
      REG_CMD: begin
        bus_rdata_o[CMD_W-1:0]     = cmd_q;
        bus_rdata_o[STAT_BUSY_BIT] = busy_o;
      end
      REG_RX:  bus_rdata_o[RX_ALL-1:0] = rx_all;
      default: bus_rdata_o = '0;
    endcase
  end

  // R7
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && busy_o) |=> $stable(cmd_q));
  // R7
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);
endmodule

// File: tb/sim_spi_mt_master.sv
`timescale 1ns/1ps
module sim_spi_mt_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd2;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy, sclk, mosi;
  logic [3:0]  cs_n, miso, crst_n;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  spi_mt_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .busy_o(busy), .sclk_o(sclk),
    .mosi_o(mosi), .cs_no(cs_n), .miso_i(miso), .chip_rst_no(crst_n)
  );

  // reference model state
  int          m_cyc = 0, m_t0 = 0, m_half = 1;
  bit          m_active = 0;
  logic [27:0] m_cmd = '0;
  logic [1:0]  m_div = '0;
  logic [3:0]  m_rst = '0;
  logic [7:0]  m_rx [4] = '{default: 8'h00};
  logic [7:0]  slave [4] = '{default: 8'h00};
  logic        p_we = 0;
  logic [1:0]  p_addr = '0;
  logic [31:0] p_wdata = '0;
  logic [1:0]  idle_addr = 2'd2;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      // reset state, R2
      chk("R2 reset crst", {28'b0, crst_n}, 32'h0);
      chk("R7 reset busy", {31'b0, busy}, 32'h0);
      chk("R4 reset cs", {28'b0, cs_n}, 32'hF);
      chk("R4 reset sclk", {31'b0, sclk}, 32'h0);
      miso = 4'hF;
    end else begin
      bit prev;
      int n, idx;
      logic [31:0] exp_rd;
      m_cyc++;
      prev = m_active;
      if (m_active && ((m_cyc - m_t0) / m_half) >= 49) begin
        m_active = 0;
        if (m_cmd[23])
          for (int i = 0; i < 4; i++) if (m_cmd[24+i]) m_rx[i] = slave[i];
      end
      if (p_we) begin
        if (p_addr == 2'd0) begin
          m_div = p_wdata[1:0];
          m_rst = p_wdata[7:4];
        end else if (p_addr == 2'd1 && !prev) begin
          m_cmd    = p_wdata[27:0] & ~28'h01F_0000;
          m_t0     = m_cyc;
          m_half   = 1 << m_div;
          m_active = 1;
        end
      end
      n = m_active ? (m_cyc - m_t0) / m_half : 0;
      idx = n / 2;
      chk("R7 busy", {31'b0, busy}, {31'b0, m_active});
      chk("R1 sclk", {31'b0, sclk}, {31'b0, m_active && n[0]});
      chk("R4 cs", {28'b0, cs_n}, {28'b0, m_active ? ~m_cmd[27:24] : 4'hF});
      chk("R3 mosi", {31'b0, mosi}, {31'b0, (m_active && idx < 24) ? m_cmd[23-idx] : 1'b0});
      chk("R2 crst", {28'b0, crst_n}, {28'b0, m_rst});
      case (addr)
        2'd0: begin exp_rd = {24'b0, m_rst, 2'b0, m_div}; chk("R2 cfg read", rdata, exp_rd); end
        2'd1: begin exp_rd = {m_active, 3'b0, m_cmd}; chk("R8 cmd read", rdata, exp_rd); end
        2'd2: begin exp_rd = {m_rx[3], m_rx[2], m_rx[1], m_rx[0]}; chk("R5,R6 rx read", rdata, exp_rd); end
        default: chk("R8 nul read", rdata, 32'h0);
      endcase
      // slave drive: real bits only in the last 8 bit slots, junk before
      for (int i = 0; i < 4; i++)
        miso[i] = (m_active && idx >= 16 && idx < 24) ? slave[i][23-idx] : ~slave[i][0];
    end
    p_we = we; p_addr = addr; p_wdata = wdata;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0; addr = idle_addr;
  endtask

  task automatic wait_idle();
    while (m_active) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    // R2 release resets, div code 0
    wr(2'd0, 32'h0000_00F0);
    slave = '{8'hA5, 8'h3C, 8'h81, 8'h7E};
    // R6 write to chip A
    idle_addr = 2'd2;
    wr(2'd1, 32'h0100_12C3);
    wait_idle();
    // R5 read chips A and C
    wr(2'd1, 32'h0580_4000);
    wait_idle();
    // R1 div 1, partial resets; read all chips
    wr(2'd0, 32'h0000_0051);
    slave = '{8'h11, 8'hF0, 8'h0F, 8'hC7};
    idle_addr = 2'd1;
    wr(2'd1, 32'h0F80_FF00);
    repeat (10) @(posedge clk);
    // R7 dropped while busy; R1 divider change mid-frame
    wr(2'd1, 32'h0280_AAAA);
    wr(2'd0, 32'h0000_00F3);
    wait_idle();
    // R3 R8 padding bits and upper bits forced; read chip B only at div 3
    slave = '{8'h5A, 8'h96, 8'h24, 8'hE1};
    idle_addr = 2'd2;
    wr(2'd1, 32'hF29F_5500);
    // R7 write on the completing edge is dropped
    repeat (49 * 8 - 1) @(posedge clk);
    #1 we = 1'b1; addr = 2'd1; wdata = 32'h0F80_0000;
    @(posedge clk); #1;
    we = 1'b0; addr = 2'd1;
    wr(2'd1, 32'h0800_3377);
    idle_addr = 2'd3;
    wait_idle();
    // R2 reassert resets, div 0, final write to all
    wr(2'd0, 32'h0000_0000);
    idle_addr = 2'd2;
    wr(2'd1, 32'h0F00_0001);
    wait_idle();
    finish_run();
  end
endmodule